// File: doc/BRIEF.md
# Multi-Mode LCD Timing Generator

This block produces the raster timing for a parallel RGB LCD panel: an active-low horizontal sync, an active-low vertical sync, a data-enable strobe and the column and row of the pixel being shown. A 3-bit resolution code picks one of five fixed timing sets at run time. Every line runs through four phases in a fixed order: visible pixels, front porch, a sync pulse one clock wide, then back porch. Every frame runs through the same four phases counted in lines, and its vertical sync pulse is one line long.

The resolution code and a standby input are captured only on the last clock of a frame, or on any clock while the generator is blanked, so a frame that has started is never torn. While standby is in force, the counters rest at zero and the outputs stay idle. Two of the eight codes have no timing set. They raise an error flag and keep the outputs idle. The pixel clock, the pixel data path and any doubling of half-size inputs sit outside this block.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `rst_n` is low, `de` is 0, `hsync_n` and `vsync_n` are 1, `px_x` and `px_y` are 0 and `mode_err` is 0.
- R2: A running line is `HA + HFP + 1 + HBP` clocks long. Columns 0 to HA-1 are active, then come HFP front-porch clocks. `hsync_n` is low for exactly one clock, at column HA+HFP, and HBP back-porch clocks follow.
- R3: A running frame is `VA + VFP + 1 + VBP` lines long, in the same phase order. `vsync_n` is low for every clock of line VA+VFP, and high on all other lines.
- R4: The timing sets, written as HA/HFP/HBP and VA/VFP/VBP, are: code 7 = 800/40/216 and 480/10/35; code 6 = 640/24/136 and 480/18/27; code 5 = 480/2/43 and 272/2/12; code 4 = 480/2/43 and 640/4/8; code 0 = 400/20/108 and 240/2/20.
- R5: Code 1 produces exactly the same timing as code 5.
- R6: When code 2 or 3 is captured, `mode_err` is 1, and `de`, `px_x` and `px_y` are 0 while both syncs stay high, for as long as that code remains captured.
- R7: `de` is 1 only on active columns of active lines. While `de` is 1, `px_x` and `px_y` give the column and row counted from 0. While `de` is 0, both are 0.
- R8: The code and `standby` are captured only on the clock edge that ends the last clock of a frame, or on any clock edge while the generator is blanked. Changes made in the middle of a frame have no effect on that frame.
- R9: While a captured `standby` is 1 with a legal code, the counters are held at zero, `de` is 0, the syncs are high and `mode_err` is 0.
- R10: After `rst_n` rises, the internal reset is released in step with the clock. On the third rising clock edge, the first frame starts at column 0 and row 0 with `de` high. A generator leaving blanking starts on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_code | input | 3 | Resolution code, captured at frame boundaries |
| standby | input | 1 | Blank request, captured at frame boundaries |
| hsync_n | output | 1 | Horizontal sync, low for one clock per line |
| vsync_n | output | 1 | Vertical sync, low for one line per frame |
| de | output | 1 | Data enable, high on visible pixels |
| px_x | output | 11 | Visible column, 0 outside the visible area |
| px_y | output | 10 | Visible row, 0 outside the visible area |
| mode_err | output | 1 | Captured code has no timing set |

## Verification
The assertions watch, on every clock, the properties that need no knowledge of the selected mode. The horizontal pulse is one clock wide. The vertical sync can only fall at the first column of a line. Every burst of `de` starts at column zero. The error flag forces idle outputs. The counters rest at zero while blanked, and a running frame is never stopped before its last clock. The exact porch and sync positions of each code, the sharing of one timing set by codes 1 and 5, and the immunity of a frame to mid-frame changes of code or standby can only be shown by the bench. It compares whole frames and lines against positions computed from the timing table, while random code and standby changes are made mid-frame.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  // Counter widths: horizontal must hold the longest line, vertical the tallest frame
  localparam int HCW   = 11;
  localparam int VCW   = 10;
  localparam int CODEW = 3;

  // Raw timing set chosen by a resolution code
  typedef struct packed {
    logic           valid;
    logic [HCW-1:0] h_act;
    logic [HCW-1:0] h_fp;
    logic [HCW-1:0] h_bp;
    logic [VCW-1:0] v_act;
    logic [VCW-1:0] v_fp;
    logic [VCW-1:0] v_bp;
  } tg_mode_t;

  // Captured configuration with precomputed boundaries
  typedef struct packed {
    logic           run;
    logic           err;
    logic [HCW-1:0] h_act;
    logic [HCW-1:0] h_sync;
    logic [HCW-1:0] h_last;
    logic [VCW-1:0] v_act;
    logic [VCW-1:0] v_sync;
    logic [VCW-1:0] v_last;
  } tg_cfg_t;

  function automatic tg_mode_t mk_mode(input int ha, input int hf, input int hb,
                                       input int va, input int vf, input int vb);
    tg_mode_t m;
    m.valid = 1'b1;
    m.h_act = HCW'(ha);
    m.h_fp  = HCW'(hf);
    m.h_bp  = HCW'(hb);
    m.v_act = VCW'(va);
    m.v_fp  = VCW'(vf);
    m.v_bp  = VCW'(vb);
    return m;
  endfunction
endpackage

// File: rtl/lcd_tg_mode_dec.sv
module lcd_tg_mode_dec
  import lcd_tg_pkg::*;
(
  input  logic [CODEW-1:0] code,
  output tg_mode_t         mode
);
  // Codes 2 and 3 carry no timing set and decode as invalid
  always_comb begin
    mode = '0;
    case (code)
      3'd7:       mode = mk_mode(800, 40, 216, 480, 10, 35);
      3'd6:       mode = mk_mode(640, 24, 136, 480, 18, 27);
      3'd5, 3'd1: mode = mk_mode(480,  2,  43, 272,  2, 12);
      3'd4:       mode = mk_mode(480,  2,  43, 640,  4,  8);
      3'd0:       mode = mk_mode(400, 20, 108, 240,  2, 20);
      default:    mode = '0;
    endcase
  end
endmodule

// File: rtl/lcd_tg_cfg_reg.sv
module lcd_tg_cfg_reg
  import lcd_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CODEW-1:0] code,
  input  logic             standby,
  input  logic             load,
  output tg_cfg_t          cfg_q
);
  tg_mode_t mode;
  tg_cfg_t  cfg_d;

  lcd_tg_mode_dec u_dec (
    .code (code),
    .mode (mode)
  );

  // Next configuration: boundaries derived once so the counters only compare
  always_comb begin
    cfg_d = '0;
    cfg_d.err = !mode.valid;
    if (mode.valid) begin
      cfg_d.run    = !standby;
      cfg_d.h_act  = mode.h_act;
      cfg_d.h_sync = mode.h_act + mode.h_fp;
      cfg_d.h_last = mode.h_act + mode.h_fp + mode.h_bp;
      cfg_d.v_act  = mode.v_act;
      cfg_d.v_sync = mode.v_act + mode.v_fp;
      cfg_d.v_last = mode.v_act + mode.v_fp + mode.v_bp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/lcd_tg_counter.sv
module lcd_tg_counter
  import lcd_tg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [HCW-1:0] h_last,
  input  logic [VCW-1:0] v_last,
  output logic [HCW-1:0] h_q,
  output logic [VCW-1:0] v_q,
  output logic           frame_end
);
  logic [HCW-1:0] h_d;
  logic [VCW-1:0] v_d;
  logic           line_end;

  always_comb begin
    line_end  = (h_q == h_last);
    frame_end = run && line_end && (v_q == v_last);
    h_d = h_q;
    v_d = v_q;
    if (!run) begin
      h_d = '0;
      v_d = '0;
    end else if (line_end) begin
      h_d = '0;
      v_d = (v_q == v_last) ? '0 : v_q + 1'b1;
    end else begin
      h_d = h_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  // R9
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (h_q == '0 && v_q == '0));
endmodule

// File: rtl/lcd_tg_decode.sv
module lcd_tg_decode
  import lcd_tg_pkg::*;
(
  input  tg_cfg_t        cfg,
  input  logic [HCW-1:0] h,
  input  logic [VCW-1:0] v,
  output logic           hsync_n,
  output logic           vsync_n,
  output logic           de,
  output logic [HCW-1:0] px_x,
  output logic [VCW-1:0] px_y,
  output logic           mode_err
);
  always_comb begin
    de       = cfg.run && (h < cfg.h_act) && (v < cfg.v_act);
    hsync_n  = !(cfg.run && (h == cfg.h_sync));
    vsync_n  = !(cfg.run && (v == cfg.v_sync));
    px_x     = de ? h : '0;
    px_y     = de ? v : '0;
    mode_err = cfg.err;
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CODEW-1:0] mode_code,
  input  logic             standby,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             de,
  output logic [HCW-1:0]   px_x,
  output logic [VCW-1:0]   px_y,
  output logic             mode_err
);
  logic [1:0]     rst_sr;
  logic           rst_s;
  logic           load;
  logic           frame_end;
  tg_cfg_t        cfg;
  logic [HCW-1:0] h_cnt;
  logic [VCW-1:0] v_cnt;

  // Reset asserts at once and releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sr <= '0;
    end else begin
      rst_sr <= {rst_sr[0], 1'b1};
    end
  end
  assign rst_s = rst_sr[1];

  // Capture only when idle or on the last clock of a frame
  assign load = !cfg.run || frame_end;

  lcd_tg_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_s),
    .code    (mode_code),
    .standby (standby),
    .load    (load),
    .cfg_q   (cfg)
  );

  lcd_tg_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_s),
    .run       (cfg.run),
    .h_last    (cfg.h_last),
    .v_last    (cfg.v_last),
    .h_q       (h_cnt),
    .v_q       (v_cnt),
    .frame_end (frame_end)
  );

  lcd_tg_decode u_dec (
    .cfg      (cfg),
    .h        (h_cnt),
    .v        (v_cnt),
    .hsync_n  (hsync_n),
    .vsync_n  (vsync_n),
    .de       (de),
    .px_x     (px_x),
    .px_y     (px_y),
    .mode_err (mode_err)
  );

  // R2
  hsync_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !hsync_n |=> hsync_n);

  // R3
  vsync_line_start_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(vsync_n) |-> (h_cnt == '0));

  // R6
  illegal_blank_chk: assert property (@(posedge clk) disable iff (!rst_s)
    mode_err |-> (!de && hsync_n && vsync_n));

  // R7
  de_origin_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(de) |-> (px_x == '0));

  // R8
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (cfg.run && !frame_end) |=> (cfg.run && $stable(cfg)));
endmodule

// File: tb/lcd_timing_gen_tb_top.sv
module lcd_timing_gen_tb_top;
  import lcd_tg_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CODEW-1:0] mode_code;
  logic             standby;
  logic             hsync_n, vsync_n, de, mode_err;
  logic [HCW-1:0]   px_x;
  logic [VCW-1:0]   px_y;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lcd_timing_gen dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_code (mode_code),
    .standby   (standby),
    .hsync_n   (hsync_n),
    .vsync_n   (vsync_n),
    .de        (de),
    .px_x      (px_x),
    .px_y      (px_y),
    .mode_err  (mode_err)
  );

  // Timing table from the requirements (R4, R5)
  function automatic void tmg(input int c, output int ha, output int hf, output int hb,
                              output int va, output int vf, output int vb);
    ha = 0; hf = 0; hb = 0; va = 0; vf = 0; vb = 0;
    case (c)
      7:    begin ha = 800; hf = 40; hb = 216; va = 480; vf = 10; vb = 35; end
      6:    begin ha = 640; hf = 24; hb = 136; va = 480; vf = 18; vb = 27; end
      5, 1: begin ha = 480; hf = 2;  hb = 43;  va = 272; vf = 2;  vb = 12; end
      4:    begin ha = 480; hf = 2;  hb = 43;  va = 640; vf = 4;  vb = 8;  end
      0:    begin ha = 400; hf = 20; hb = 108; va = 240; vf = 2;  vb = 20; end
      default: ;
    endcase
  endfunction

  function automatic int line_len(input int c);
    int ha, hf, hb, va, vf, vb;
    tmg(c, ha, hf, hb, va, vf, vb);
    return ha + hf + 1 + hb;
  endfunction

  function automatic int frame_len(input int c);
    int ha, hf, hb, va, vf, vb;
    tmg(c, ha, hf, hb, va, vf, vb);
    return (ha + hf + 1 + hb) * (va + vf + 1 + vb);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compares n consecutive clocks starting at frame position t0; one check
  task automatic run_window(input int c, input int t0, input int n, input string req);
    int ha, hf, hb, va, vf, vb, ht, vt;
    bit bad;
    int bpos, bact, bexp;
    string bwhat;
    bad = 1'b0; bpos = 0; bact = 0; bexp = 0; bwhat = "";
    tmg(c, ha, hf, hb, va, vf, vb);
    ht = ha + hf + 1 + hb;
    vt = va + vf + 1 + vb;
    for (int i = 0; i < n; i++) begin
      int t, h, v, ex, ey;
      bit ede, ehs, evs;
      t   = t0 + i;
      h   = t % ht;
      v   = (t / ht) % vt;
      ede = (h < ha) && (v < va);
      ehs = !(h == ha + hf);
      evs = !(v == va + vf);
      ex  = ede ? h : 0;
      ey  = ede ? v : 0;
      if (!bad) begin
        bpos = t;
        if (de !== ede) begin bad = 1; bwhat = "de"; bact = int'(de); bexp = int'(ede); end
        else if (hsync_n !== ehs) begin bad = 1; bwhat = "hsync_n"; bact = int'(hsync_n); bexp = int'(ehs); end
        else if (vsync_n !== evs) begin bad = 1; bwhat = "vsync_n"; bact = int'(vsync_n); bexp = int'(evs); end
        else if (px_x !== HCW'(ex)) begin bad = 1; bwhat = "px_x"; bact = int'(px_x); bexp = ex; end
        else if (px_y !== VCW'(ey)) begin bad = 1; bwhat = "px_y"; bact = int'(px_y); bexp = ey; end
        else if (mode_err !== 1'b0) begin bad = 1; bwhat = "mode_err"; bact = int'(mode_err); bexp = 0; end
      end
      @(negedge clk);
    end
    n_chk++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s code %0d pos %0d %s: got %0d expected %0d",
               req, c, bpos, bwhat, bact, bexp);
    end
  endtask

  // Idle outputs for n clocks with a given error flag; one check
  task automatic check_blank(input int n, input bit err_exp, input string req);
    bit bad;
    string bwhat;
    int bact, bexp;
    bad = 1'b0; bwhat = ""; bact = 0; bexp = 0;
    for (int i = 0; i < n; i++) begin
      if (!bad) begin
        if (de !== 1'b0) begin bad = 1; bwhat = "de"; bact = int'(de); bexp = 0; end
        else if (hsync_n !== 1'b1) begin bad = 1; bwhat = "hsync_n"; bact = int'(hsync_n); bexp = 1; end
        else if (vsync_n !== 1'b1) begin bad = 1; bwhat = "vsync_n"; bact = int'(vsync_n); bexp = 1; end
        else if (px_x !== '0) begin bad = 1; bwhat = "px_x"; bact = int'(px_x); bexp = 0; end
        else if (px_y !== '0) begin bad = 1; bwhat = "px_y"; bact = int'(px_y); bexp = 0; end
        else if (mode_err !== err_exp) begin bad = 1; bwhat = "mode_err"; bact = int'(mode_err); bexp = int'(err_exp); end
      end
      @(negedge clk);
    end
    n_chk++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s idle %s: got %0d expected %0d", req, bwhat, bact, bexp);
    end
  endtask

  // Counts negedges until de is seen high
  task automatic wait_de(input int exp_k, input string req);
    int k;
    k = 0;
    while (de !== 1'b1 && k < 12) begin
      @(negedge clk);
      k++;
    end
    chk(de === 1'b1 && k == exp_k, req, "clocks to first active pixel", k, exp_k);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 195000, 0);
    finish_run();
  end

  initial begin
    int pos, fl0, cut;
    int order [4];
    void'($urandom(32'd4242));
    order = '{6, 5, 4, 1};
    rst_n     = 1'b0;
    mode_code = 3'd0;
    standby   = 1'b0;
    repeat (4) @(negedge clk);

    // R1: idle state under reset
    check_blank(4, 1'b0, "R1");

    // R10: first frame begins on the third edge after release
    rst_n = 1'b1;
    wait_de(3, "R10");

    // R3 R7: code 0 frame, then mid-frame changes that must be ignored (R8)
    fl0 = frame_len(0);
    cut = int'($urandom_range(60000, 2000));
    run_window(0, 0, cut, "R3 R7");
    pos = cut;
    for (int c = 0; c < 3; c++) begin
      int len;
      len = int'($urandom_range(20000, 500));
      mode_code = 3'($urandom_range(7, 0));
      standby   = 1'($urandom_range(1, 0));
      run_window(0, pos, len, "R8");
      pos += len;
    end
    mode_code = 3'd7;
    standby   = 1'b1;
    run_window(0, pos, fl0 - pos, "R8");

    // R9: standby captured at the frame boundary
    check_blank(25, 1'b0, "R9");

    // R6: illegal codes captured while idle
    mode_code = 3'd2;
    standby   = 1'b0;
    @(negedge clk);
    check_blank(30, 1'b1, "R6");
    mode_code = 3'd3;
    @(negedge clk);
    check_blank(30, 1'b1, "R6");

    // R8: leaving the idle state starts a frame on the next edge
    mode_code = 3'd7;
    wait_de(1, "R8");
    run_window(7, 0, 3 * line_len(7), "R2 R4");

    // R4 R5: remaining codes in random order, each from a fresh reset
    for (int i = 0; i < 4; i++) begin
      int j, tmp;
      j = int'($urandom_range(3, 0));
      tmp = order[i];
      order[i] = order[j];
      order[j] = tmp;
    end
    for (int i = 0; i < 4; i++) begin
      rst_n     = 1'b0;
      mode_code = 3'(order[i]);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      wait_de(3, "R10");
      run_window(order[i], 0, 3 * line_len(order[i]), (order[i] == 1) ? "R5" : "R4");
    end

    finish_run();
  end
endmodule